// File: doc/BRIEF.md
# Sleep-time interrupt capture and replay unit

This block sits between a set of external interrupt lines and a parent interrupt controller. Each line is first brought into the local clock domain. The line is then watched for an edge or for an active level, according to its own sensitivity and polarity settings. When a qualifying event occurs, a per-line status bit is latched. Latching happens whether or not the unit is enabled, so events that arrive while the system sleeps are held. On wake-up, software issues a flush command. The unit then sends one single-cycle pulse to the parent for each recorded, unmasked line, and clears those status bits.

Software reaches the unit through a simple register bus with one-cycle read latency. The mask, sensitivity and polarity attributes each have a write-one-to-set bank and a write-one-to-clear bank. An acknowledge bank clears recorded status. A control word holds an enable bit, an edge-only recording bit and a self-clearing flush bit. The line count is a parameter of up to 64. Lines are packed 32 to a 32-bit word, so line i sits in word i/32 at bit i%32.

Top module: `irq_replay_unit`

## Requirements
- R1: After reset, irq_o is all zero. All status bits are zero. Every line is masked. Sensitivity is all zero (edge). Polarity is all one. The control word reads zero.
- R2: Register byte offsets are as follows. Acknowledge is at 0x40. Mask set is at 0xC0 and mask clear at 0x100. Sense set is at 0x180 and sense clear at 0x1C0. Polarity set is at 0x240 and polarity clear at 0x280. Control is at 0x300. Word w of a bank sits at offset + 4*w, and line i is bit i%32 of word i/32. Reading either address of a set/clear pair returns the current attribute. Reading the acknowledge address returns the status bits. Unused bits and unmapped addresses read 0. Read data appears in the cycle after the request.
- R3: In every set or clear bank, a 1 bit sets or clears that line's attribute, and a 0 bit leaves it unchanged.
- R4: A line in edge mode (sense 0) records a rising edge when its polarity is 1 and a falling edge when its polarity is 0. The opposite edge is not recorded. Status stays latched after the line returns to idle.
- R5: A line in level mode (sense 1) records while its synchronized value equals its polarity bit. The level is not recorded while control bit 1 (edge-only) is set. Edge-mode lines still record in that state.
- R6: Events are recorded while control bit 0 (enable) is clear.
- R7: A masked line (mask bit 1) records no new event and is not replayed by a flush. Status it already holds is kept.
- R8: Writing 1 to a line's acknowledge bit clears its status. An event detected in the same cycle wins, so an active level stays recorded.
- R9: A control write with bit 2 (flush) and bit 0 (enable) both set does two things at that write's clock edge. It drives irq_o high for exactly one cycle on every recorded, unmasked line. It also clears those status bits. Bit 2 always reads back as 0.
- R10: A control write with bit 2 set and bit 0 clear produces no pulse and leaves status unchanged.
- R11: An event detected on a line in the same cycle that the line is replayed is dropped. An event on a line not being replayed in that cycle is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | External interrupt lines, asynchronous |
| irq_o | output | NUM_LINES | Replay pulses to the parent controller |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after a read request |

## Verification
The bench walks a rising edge across every line of a 40-line configuration. A design that mixes up the word or bit mapping would set the wrong status bit, or a bit in the wrong word. Both polarities are exercised in edge and level mode, and edge-only recording is also covered. A swapped polarity would record the idle transition. Level lines that are still recorded in edge-only mode would show a spurious status bit. The bench acknowledges a line while its level is still active; a design that let the acknowledge win would lose that interrupt. The flush is checked for a single-cycle pulse, for masked lines, and for a flush written without enable. One flush is timed to land in the exact cycle that a new event is detected. This catches a design that would replay the event twice or drop the event on the neighbouring line.

// File: rtl/irq_replay_pkg.sv
package irq_replay_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_ACK  = 12'h040;
  localparam logic [REG_AW-1:0] OFS_MSET = 12'h0C0;
  localparam logic [REG_AW-1:0] OFS_MCLR = 12'h100;
  localparam logic [REG_AW-1:0] OFS_SSET = 12'h180;
  localparam logic [REG_AW-1:0] OFS_SCLR = 12'h1C0;
  localparam logic [REG_AW-1:0] OFS_PSET = 12'h240;
  localparam logic [REG_AW-1:0] OFS_PCLR = 12'h280;
  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h300;

  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned CTRL_EDGE  = 1;
  localparam int unsigned CTRL_FLUSH = 2;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] cur_i,
  input  logic [NUM_LINES-1:0] prev_i,
  input  logic [NUM_LINES-1:0] sense_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic                 edge_only_i,
  output logic [NUM_LINES-1:0] event_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic edge_hit, level_hit;
    // pol=1: rising / high, pol=0: falling / low
    assign edge_hit  = pol_i[i] ? (cur_i[i] & ~prev_i[i]) : (~cur_i[i] & prev_i[i]);
    assign level_hit = ~edge_only_i & (cur_i[i] == pol_i[i]);
    assign event_o[i] = sense_i[i] ? level_hit : edge_hit;
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_replay_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [REG_DW-1:0]    wdata_i,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] sense_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] ack_o,
  output logic                 en_o,
  output logic                 edge_only_o,
  output logic                 flush_o,
  output logic [REG_DW-1:0]    rdata_o
);
  localparam int unsigned NW = (NUM_LINES + REG_DW - 1) / REG_DW;

  logic [NW-1:0] hit_ack, hit_mset, hit_mclr, hit_sset, hit_sclr, hit_pset, hit_pclr;
  logic          hit_ctrl, wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam logic [REG_AW-1:0] WOFS = REG_AW'(4 * w);
    assign hit_ack[w]  = req_i && (addr_i == OFS_ACK  + WOFS);
    assign hit_mset[w] = req_i && (addr_i == OFS_MSET + WOFS);
    assign hit_mclr[w] = req_i && (addr_i == OFS_MCLR + WOFS);
    assign hit_sset[w] = req_i && (addr_i == OFS_SSET + WOFS);
    assign hit_sclr[w] = req_i && (addr_i == OFS_SCLR + WOFS);
    assign hit_pset[w] = req_i && (addr_i == OFS_PSET + WOFS);
    assign hit_pclr[w] = req_i && (addr_i == OFS_PCLR + WOFS);
  end
  assign hit_ctrl = req_i && (addr_i == OFS_CTRL);

  logic [NUM_LINES-1:0] mask_q, sense_q, pol_q;
  logic [NUM_LINES-1:0] mset, mclr, sset, sclr, pset, pclr, ack;
  logic                 en_q, edge_q;
  logic [REG_DW-1:0]    rd_d, rdata_q;

  always_comb begin
    mset = '0; mclr = '0; sset = '0; sclr = '0; pset = '0; pclr = '0; ack = '0;
    rd_d = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      mset[i] = wr & hit_mset[i/32] & wdata_i[i%32];
      mclr[i] = wr & hit_mclr[i/32] & wdata_i[i%32];
      sset[i] = wr & hit_sset[i/32] & wdata_i[i%32];
      sclr[i] = wr & hit_sclr[i/32] & wdata_i[i%32];
      pset[i] = wr & hit_pset[i/32] & wdata_i[i%32];
      pclr[i] = wr & hit_pclr[i/32] & wdata_i[i%32];
      ack[i]  = wr & hit_ack[i/32]  & wdata_i[i%32];
      if (hit_ack[i/32])                    rd_d[i%32] = status_i[i];
      if (hit_mset[i/32] | hit_mclr[i/32])  rd_d[i%32] = mask_q[i];
      if (hit_sset[i/32] | hit_sclr[i/32])  rd_d[i%32] = sense_q[i];
      if (hit_pset[i/32] | hit_pclr[i/32])  rd_d[i%32] = pol_q[i];
    end
    if (hit_ctrl) begin
      rd_d[CTRL_EN]   = en_q;
      rd_d[CTRL_EDGE] = edge_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      sense_q <= '0;
      pol_q   <= '1;
      en_q    <= 1'b0;
      edge_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      mask_q  <= (mask_q  | mset) & ~mclr;
      sense_q <= (sense_q | sset) & ~sclr;
      pol_q   <= (pol_q   | pset) & ~pclr;
      if (wr && hit_ctrl) begin
        en_q   <= wdata_i[CTRL_EN];
        edge_q <= wdata_i[CTRL_EDGE];
      end
      if (rd) rdata_q <= rd_d;
    end
  end

  assign mask_o      = mask_q;
  assign sense_o     = sense_q;
  assign pol_o       = pol_q;
  assign ack_o       = ack;
  assign en_o        = en_q;
  assign edge_only_o = edge_q;
  // flush acts only when the same write keeps the unit enabled
  assign flush_o     = wr & hit_ctrl & wdata_i[CTRL_FLUSH] & wdata_i[CTRL_EN];
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/irq_replay_unit.sv
module irq_replay_unit
  import irq_replay_pkg::*;
#(
  parameter int unsigned NUM_LINES = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] irq_o,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [REG_AW-1:0]    bus_addr_i,
  input  logic [REG_DW-1:0]    bus_wdata_i,
  output logic [REG_DW-1:0]    bus_rdata_o
);
  logic [NUM_LINES-1:0] cur, prev, evt;
  logic [NUM_LINES-1:0] mask_q, sense, pol, ack_vec;
  logic [NUM_LINES-1:0] status_q, status_d, replay, irq_q;
  logic                 ctrl_en, edge_only, flush_fire;

  irq_line_sync #(.WIDTH(NUM_LINES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  irq_event_detect #(.NUM_LINES(NUM_LINES)) i_detect (
    .cur_i      (cur),
    .prev_i     (prev),
    .sense_i    (sense),
    .pol_i      (pol),
    .edge_only_i(edge_only),
    .event_o    (evt)
  );

  irq_reg_file #(.NUM_LINES(NUM_LINES)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .status_i   (status_q),
    .mask_o     (mask_q),
    .sense_o    (sense),
    .pol_o      (pol),
    .ack_o      (ack_vec),
    .en_o       (ctrl_en),
    .edge_only_o(edge_only),
    .flush_o    (flush_fire),
    .rdata_o    (bus_rdata_o)
  );

  assign replay   = flush_fire ? (status_q & ~mask_q) : '0;
  // new events beat ack; replay beats new events on the replayed bits only
  assign status_d = ((status_q & ~ack_vec) | (evt & ~mask_q)) & ~replay;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= '0;
    end else begin
      status_q <= status_d;
      irq_q    <= replay;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_replay_chk.sv
module irq_replay_chk #(
  parameter int unsigned NUM_LINES = 40
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] irq_o,
  input logic [NUM_LINES-1:0] status_q,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] ack_vec,
  input logic                 flush_fire
);
  p_pulse_from_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> ((irq_o & ~$past(status_q)) == '0));

  p_single_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & $past(irq_o)) == '0);

  p_replay_drops_event_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & status_q) == '0);

  p_pulse_needs_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(flush_fire));

  p_mask_blocks_record_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~$past(status_q) & $past(mask_q)) == '0);

  p_mask_blocks_replay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & $past(mask_q)) == '0);

  p_clear_only_by_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_q) & ~status_q & ~$past(ack_vec) & ~irq_o) == '0);
endmodule

bind irq_replay_unit irq_replay_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .ack_vec   (ack_vec),
  .flush_fire(flush_fire)
);

// File: tb/test_irq_replay_unit.sv
`timescale 1ns/1ps
module test_irq_replay_unit;
  localparam int N = 40;
  localparam logic [11:0] A_ACK = 12'h040, A_MSET = 12'h0C0, A_MCLR = 12'h100,
                          A_SSET = 12'h180, A_SCLR = 12'h1C0, A_PSET = 12'h240,
                          A_PCLR = 12'h280, A_CTRL = 12'h300;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, irq_out;
  logic         req = 1'b0, we = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0, rdata;
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  irq_replay_unit #(.NUM_LINES(N)) i_irq_replay_unit (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq_in), .irq_o(irq_out),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk); d = rdata; req = 1'b0;
  endtask

  task automatic rd64(input logic [11:0] base, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(base, lo);
    rd(base + 12'h4, hi);
    d = {hi, lo};
  endtask

  task automatic wr64(input logic [11:0] base, input logic [63:0] d);
    wr(base, d[31:0]);
    wr(base + 12'h4, d[63:32]);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  localparam logic [63:0] ALL = {24'h0, 40'hFF_FFFF_FFFF};

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_o", 64'(irq_out), 64'h0);
    rd64(A_ACK, v);  chk("R1 status", v, 64'h0);
    rd64(A_MSET, v); chk("R1 mask", v, ALL);
    rd64(A_SSET, v); chk("R1 sense", v, 64'h0);
    rd64(A_PCLR, v); chk("R1 pol", v, ALL);
    rd(A_CTRL, w);   chk("R1 ctrl", 64'(w), 64'h0);

    // R2/R3 set-clear semantics and aliasing
    wr(A_MCLR, 32'h0000_00F0);
    rd(A_MSET, w); chk("R3 mask clear", 64'(w), 64'hFFFF_FF0F);
    wr(A_MSET, 32'h0000_0010);
    rd(A_MCLR, w); chk("R2 mask alias read", 64'(w), 64'hFFFF_FF1F);
    wr(A_MSET, 32'h0);
    wr(A_MCLR, 32'h0);
    rd(A_MSET, w); chk("R3 zero write no effect", 64'(w), 64'hFFFF_FF1F);
    wr(A_SSET + 12'h4, 32'h0000_0081);
    rd64(A_SCLR, v); chk("R2 word1 bit map", v, 64'h0000_0081_0000_0000);
    wr(A_SCLR + 12'h4, 32'hFFFF_FFFF);
    rd(12'h3F0, w); chk("R2 unmapped reads zero", 64'(w), 64'h0);

    // R4 rising edge sweep over every line; R6 enable stays clear
    wr64(A_MCLR, ALL);
    for (int i = 0; i < N; i++) begin
      irq_in[i] = 1'b1; settle();
      rd64(A_ACK, v); chk($sformatf("R4 rise line %0d", i), v, 64'd1 << i);
      irq_in[i] = 1'b0; settle();
      rd64(A_ACK, v); chk($sformatf("R4 held line %0d", i), v, 64'd1 << i);
      wr64(A_ACK, 64'd1 << i);
      rd64(A_ACK, v); chk($sformatf("R8 ack line %0d", i), v, 64'h0);
    end
    rd(A_CTRL, w); chk("R6 recorded while disabled", 64'(w), 64'h0);

    // R4 falling polarity on boundary lines
    wr64(A_PCLR, ALL);
    foreach (irq_in[i]) begin
      if (i == 0 || i == 31 || i == 32 || i == 39) begin
        irq_in[i] = 1'b1; settle();
        rd64(A_ACK, v); chk($sformatf("R4 fall-pol ignores rise %0d", i), v, 64'h0);
        irq_in[i] = 1'b0; settle();
        rd64(A_ACK, v); chk($sformatf("R4 fall line %0d", i), v, 64'd1 << i);
        wr64(A_ACK, 64'd1 << i);
      end
    end
    wr64(A_PSET, ALL);

    // R5 level high, R8 ack loses to active level
    wr(A_SSET, 32'h20);
    irq_in[5] = 1'b1; settle();
    rd(A_ACK, w); chk("R5 level high", 64'(w), 64'h20);
    wr(A_ACK, 32'h20); settle();
    rd(A_ACK, w); chk("R8 level re-records after ack", 64'(w), 64'h20);
    // R5 edge-only suppresses level, edge lines still record
    wr(A_CTRL, 32'h2);
    wr(A_ACK, 32'h20); settle();
    rd(A_ACK, w); chk("R5 edge-only blocks level", 64'(w), 64'h0);
    irq_in[7] = 1'b1; settle();
    rd(A_ACK, w); chk("R5 edge-only keeps edge", 64'(w), 64'h80);
    wr(A_CTRL, 32'h0);
    irq_in[5] = 1'b0; irq_in[7] = 1'b0; settle();
    wr(A_ACK, 32'hA0);
    // R5 level low
    irq_in[6] = 1'b1; settle();
    wr(A_ACK, 32'h40);
    wr(A_SSET, 32'h40); wr(A_PCLR, 32'h40); settle();
    wr(A_ACK, 32'h40); settle();
    rd(A_ACK, w); chk("R5 low level idle high", 64'(w), 64'h0);
    irq_in[6] = 1'b0; settle();
    rd(A_ACK, w); chk("R5 low level active", 64'(w), 64'h40);
    wr(A_SCLR, 32'h60); wr(A_PSET, 32'h40); settle();
    wr(A_ACK, 32'h40);
    rd64(A_ACK, v); chk("R5 cleanup", v, 64'h0);

    // R7 masked line does not record
    wr(A_MSET, 32'h400);
    irq_in[10] = 1'b1; settle();
    rd(A_ACK, w); chk("R7 masked no record", 64'(w), 64'h0);
    irq_in[10] = 1'b0;
    // record lines 2, 11, 33; then mask 11
    irq_in[2] = 1'b1; irq_in[11] = 1'b1; irq_in[33] = 1'b1; settle();
    irq_in[2] = 1'b0; irq_in[11] = 1'b0; irq_in[33] = 1'b0; settle();
    wr(A_MSET, 32'h800);

    // R9 flush
    wr(A_CTRL, 32'h5);
    chk("R9 pulse", 64'(irq_out), (64'd1 << 2) | (64'd1 << 33));
    @(negedge clk);
    chk("R9 pulse one cycle", 64'(irq_out), 64'h0);
    rd64(A_ACK, v); chk("R7 masked kept, R9 replayed cleared", v, 64'd1 << 11);
    rd(A_CTRL, w); chk("R9 flush self-clears", 64'(w), 64'h1);
    wr(A_ACK, 32'h800); wr(A_MCLR, 32'h400);

    // R10 flush without enable
    irq_in[3] = 1'b1; settle(); irq_in[3] = 1'b0; settle();
    wr(A_CTRL, 32'h4);
    chk("R10 no pulse", 64'(irq_out), 64'h0);
    rd64(A_ACK, v); chk("R10 status kept", v, 64'd1 << 3);
    wr(A_CTRL, 32'h5);
    chk("R9 pulse line 3", 64'(irq_out), 64'd1 << 3);

    // R11 flush lands in the same cycle a new event is detected
    irq_in[0] = 1'b1; settle(); irq_in[0] = 1'b0; settle();
    rd64(A_ACK, v); chk("R11 setup", v, 64'h1);
    @(negedge clk); irq_in[0] = 1'b1; irq_in[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_CTRL; wdata = 32'h5;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R11 replayed line pulses", 64'(irq_out), 64'h1);
    rd64(A_ACK, v); chk("R11 event dropped on replayed, kept on other", v, 64'h2);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule